// File: doc/BRIEF.md
# Supply-Pulse Level and Width Classifier

This block sits behind a set of three-level supply comparators. A free-running clock samples their coded output, and the block turns the stream into programming symbols. Each symbol is a single-cycle event. A mid-level pulse that has ended gives one event. A short high pulse (a key pulse) that has ended gives another. A long high pulse (a blow pulse) gives a third, which fires while the pulse is still present. The block also raises an error event when a pulse, or the low gap before it, is too short. A drop to ground gives a power-loss event that downstream logic uses to clear its state.

The raw level must hold for a programmable number of cycles before it is accepted. This filter hides the slow supply edges and any brief excursions through the mid band. A pulse is classified by the highest filtered level it reached and by how many cycles it stayed active. All widths are in clock cycles and are set by parameters.

Top module: `supply_pulse_classifier`

## Requirements
- R1: During reset and after its release, all five event outputs are low and the filtered level is ground. The first pulse after reset is judged as if it came straight out of ground.
- R2: `supLvl` is coded as 0 = ground, 1 = low, 2 = mid, 3 = high. The filtered level takes a new value only on the clock edge where that value has been sampled on FILT_CYC consecutive edges. Shorter excursions have no effect on any output.
- R3: A pulse ends when the filtered level returns to low. If that pulse reached mid but never high, lasted at least MIN_ACT cycles and followed a valid gap, `midDone` is high for exactly one cycle, on the cycle after the return to low.
- R4: A pulse that reached high, lasted at least MIN_ACT but fewer than BLOW_CYC cycles and followed a valid gap gives one `keyDone` cycle, on the cycle after the return to low.
- R5: `blowStart` is high for one cycle, once per pulse, on the cycle after the BLOW_CYC-th active cycle of a high pulse with a valid gap. When such a pulse ends, neither `keyDone` nor `midDone` is raised.
- R6: A gap is valid when at least MIN_GAP filtered-low cycles came before the pulse. If the pulse is shorter than MIN_ACT, or its gap is not valid, its symbol is dropped and `pulseErr` is high for one cycle when it returns to low.
- R7: A high pulse whose edge passes through the mid band is classified by its highest level. It gives `keyDone` and never `midDone`.
- R8: When the filtered level falls to ground from any other level, `pwrLoss` is high for one cycle. A pulse cut off in this way gives no other event, and the next pulse needs a fresh valid gap.
- R9: At most one of the five event outputs is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| supLvl | input | 2 | Comparator code: 0 ground, 1 low, 2 mid, 3 high |
| midDone | output | 1 | Mid pulse completed |
| keyDone | output | 1 | Short high (key) pulse completed |
| blowStart | output | 1 | High pulse has reached blow duration |
| pulseErr | output | 1 | Pulse or preceding gap too short, symbol dropped |
| pwrLoss | output | 1 | Supply fell to ground |

## Verification
The bench sends high pulses that linger in the mid band for fewer cycles than the filter needs. A classifier that latched the first active level would report these as mid symbols. A gap only half the minimum comes just before a well-formed mid pulse, and a design that did not check gaps would let that symbol through. A long high pulse must fire the blow event exactly once and then give no key on its falling edge. A pulse cut off by ground must give only the power-loss event. A pulse that rises straight out of ground must be rejected, because a design that kept the old gap count would accept it. Brief spikes inside a low gap must leave every output quiet.

// File: rtl/spc_pkg.sv
package spc_pkg;
  typedef enum logic [1:0] {
    LVL_GND  = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_MID  = 2'd2,
    LVL_HIGH = 2'd3
  } lvl_e;

  typedef struct packed {
    logic cntGap;
    logic cntWidth;
  } dpStrobe_t;
endpackage

// File: rtl/spc_satcnt.sv
module spc_satcnt #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rstN)                    count <= '0;
    else if (!inc)                count <= '0;
    else if (count != CNT_MAX)    count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/spc_datapath.sv
module spc_datapath
  import spc_pkg::*;
#(
  parameter int FILT_CYC = 64,
  parameter int CNT_W    = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  lvl_e             rawLvl,
  input  dpStrobe_t        strobe,
  output lvl_e             filtLvl,
  output logic [CNT_W-1:0] gapCnt,
  output logic [CNT_W-1:0] widthCnt
);
  localparam int RUN_W = $clog2(FILT_CYC + 1);
  localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(FILT_CYC);

  lvl_e             lastRaw;
  logic [RUN_W-1:0] runLen;
  logic [RUN_W-1:0] runNext;

  always_comb begin
    if (rawLvl != lastRaw)     runNext = RUN_W'(1);
    else if (runLen == RUN_FULL) runNext = runLen;
    else                       runNext = runLen + RUN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastRaw <= LVL_GND;
      runLen  <= '0;
      filtLvl <= LVL_GND;
    end else begin
      lastRaw <= rawLvl;
      runLen  <= runNext;
      if (runNext == RUN_FULL) filtLvl <= rawLvl;
    end
  end

  spc_satcnt #(.CNT_W(CNT_W)) gapCounter (
    .clk(clk), .rstN(rstN), .inc(strobe.cntGap), .count(gapCnt)
  );

  spc_satcnt #(.CNT_W(CNT_W)) widthCounter (
    .clk(clk), .rstN(rstN), .inc(strobe.cntWidth), .count(widthCnt)
  );
endmodule

// File: rtl/spc_control.sv
module spc_control
  import spc_pkg::*;
#(
  parameter int MIN_ACT  = 1000,
  parameter int MIN_GAP  = 1000,
  parameter int BLOW_CYC = 4500,
  parameter int CNT_W    = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  lvl_e             filtLvl,
  input  logic [CNT_W-1:0] gapCnt,
  input  logic [CNT_W-1:0] widthCnt,
  output dpStrobe_t        strobe,
  output logic             midDone,
  output logic             keyDone,
  output logic             blowStart,
  output logic             pulseErr,
  output logic             pwrLoss
);
  localparam logic [CNT_W-1:0] ACT_MIN  = CNT_W'(MIN_ACT);
  localparam logic [CNT_W-1:0] GAP_MIN  = CNT_W'(MIN_GAP);
  localparam logic [CNT_W-1:0] BLOW_LIM = CNT_W'(BLOW_CYC);
  localparam logic [CNT_W-1:0] BLOW_HIT = CNT_W'(BLOW_CYC - 1);

  typedef enum logic [1:0] {ST_OFF, ST_GAP, ST_PULSE} state_e;

  state_e state;
  logic   gapOk;
  logic   highSeen;
  logic   isActive;
  logic   isHigh;

  assign isHigh          = (filtLvl == LVL_HIGH);
  assign isActive        = isHigh || (filtLvl == LVL_MID);
  assign strobe.cntGap   = (filtLvl == LVL_LOW);
  assign strobe.cntWidth = isActive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_OFF;
      gapOk     <= 1'b0;
      highSeen  <= 1'b0;
      midDone   <= 1'b0;
      keyDone   <= 1'b0;
      blowStart <= 1'b0;
      pulseErr  <= 1'b0;
      pwrLoss   <= 1'b0;
    end else begin
      midDone   <= 1'b0;
      keyDone   <= 1'b0;
      blowStart <= 1'b0;
      pulseErr  <= 1'b0;
      pwrLoss   <= 1'b0;
      if (filtLvl == LVL_GND) begin
        if (state != ST_OFF) pwrLoss <= 1'b1;
        state <= ST_OFF;
      end else if (filtLvl == LVL_LOW) begin
        if (state == ST_PULSE) begin
          if (!gapOk || widthCnt < ACT_MIN) pulseErr <= 1'b1;
          else if (!highSeen)               midDone  <= 1'b1;
          else if (widthCnt < BLOW_LIM)     keyDone  <= 1'b1;
        end
        state <= ST_GAP;
      end else if (state != ST_PULSE) begin
        gapOk    <= (state == ST_GAP) && (gapCnt >= GAP_MIN);
        highSeen <= isHigh;
        state    <= ST_PULSE;
      end else begin
        highSeen <= highSeen | isHigh;
        if (isHigh && gapOk && widthCnt == BLOW_HIT) blowStart <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/supply_pulse_classifier.sv
module supply_pulse_classifier
  import spc_pkg::*;
#(
  parameter int FILT_CYC = 64,
  parameter int MIN_ACT  = 1000,
  parameter int MIN_GAP  = 1000,
  parameter int BLOW_CYC = 4500,
  parameter int CNT_W    = 14
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] supLvl,
  output logic       midDone,
  output logic       keyDone,
  output logic       blowStart,
  output logic       pulseErr,
  output logic       pwrLoss
);
  lvl_e             filtLvl;
  logic [CNT_W-1:0] gapCnt;
  logic [CNT_W-1:0] widthCnt;
  dpStrobe_t        strobe;

  spc_datapath #(.FILT_CYC(FILT_CYC), .CNT_W(CNT_W)) dp (
    .clk(clk), .rstN(rstN), .rawLvl(lvl_e'(supLvl)), .strobe(strobe),
    .filtLvl(filtLvl), .gapCnt(gapCnt), .widthCnt(widthCnt)
  );

  spc_control #(.MIN_ACT(MIN_ACT), .MIN_GAP(MIN_GAP), .BLOW_CYC(BLOW_CYC),
                .CNT_W(CNT_W)) ctl (
    .clk(clk), .rstN(rstN), .filtLvl(filtLvl), .gapCnt(gapCnt),
    .widthCnt(widthCnt), .strobe(strobe), .midDone(midDone),
    .keyDone(keyDone), .blowStart(blowStart), .pulseErr(pulseErr),
    .pwrLoss(pwrLoss)
  );
endmodule

// File: rtl/spc_checker.sv
module spc_checker
  import spc_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic [1:0] supLvl,
  input lvl_e       filtLvl,
  input logic       midDone,
  input logic       keyDone,
  input logic       blowStart,
  input logic       pulseErr,
  input logic       pwrLoss
);
  // R2
  filt_follows_raw_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(filtLvl) |-> $past(supLvl) == filtLvl);
  // R3
  mid_after_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    midDone |-> $past(filtLvl) == LVL_LOW);
  // R4
  key_after_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    keyDone |-> $past(filtLvl) == LVL_LOW);
  // R5
  blow_on_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    blowStart |-> $past(filtLvl) == LVL_HIGH);
  // R5
  blow_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    blowStart |=> !blowStart);
  // R6
  err_after_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    pulseErr |-> $past(filtLvl) == LVL_LOW);
  // R8
  loss_after_gnd_chk: assert property (@(posedge clk) disable iff (!rstN)
    pwrLoss |-> $past(filtLvl) == LVL_GND);
  // R9
  one_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({midDone, keyDone, blowStart, pulseErr, pwrLoss}));
endmodule

bind supply_pulse_classifier spc_checker chk (
  .clk(clk), .rstN(rstN), .supLvl(supLvl), .filtLvl(filtLvl),
  .midDone(midDone), .keyDone(keyDone), .blowStart(blowStart),
  .pulseErr(pulseErr), .pwrLoss(pwrLoss)
);

// File: tb/supply_pulse_classifier_test.sv
module supply_pulse_classifier_test;
  localparam int FILT = 4;
  localparam int MACT = 20;
  localparam int MGAP = 20;
  localparam int BLOW = 90;
  localparam int CW   = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] supLvl = 2'd0;
  logic midDone, keyDone, blowStart, pulseErr, pwrLoss;

  always #10 clk = ~clk;

  supply_pulse_classifier #(.FILT_CYC(FILT), .MIN_ACT(MACT), .MIN_GAP(MGAP),
    .BLOW_CYC(BLOW), .CNT_W(CW)) uut (
    .clk(clk), .rstN(rstN), .supLvl(supLvl), .midDone(midDone),
    .keyDone(keyDone), .blowStart(blowStart), .pulseErr(pulseErr),
    .pwrLoss(pwrLoss)
  );

  int nTests = 0, nFail = 0, cycles = 0;
  bit done = 0;

  // behavioural reference: state 0 off, 1 gap, 2 pulse
  int mLast, mRun, mFilt, mState, mGap, mWidth;
  bit mGapOk, mHigh;
  bit eMid, eKey, eBlow, eErr, ePwr;
  int cMid, cKey, cBlow, cErr, cPwr;

  always @(posedge clk) begin
    if (!rstN) begin
      mLast = 0; mRun = 0; mFilt = 0; mState = 0; mGap = 0; mWidth = 0;
      mGapOk = 0; mHigh = 0;
      {eMid, eKey, eBlow, eErr, ePwr} = '0;
    end else begin
      {eMid, eKey, eBlow, eErr, ePwr} = '0;
      if (mFilt == 0) begin
        if (mState != 0) ePwr = 1;
        mState = 0;
      end else if (mFilt == 1) begin
        if (mState == 2) begin
          if (!mGapOk || mWidth < MACT) eErr = 1;
          else if (!mHigh) eMid = 1;
          else if (mWidth < BLOW) eKey = 1;
        end
        mState = 1;
      end else if (mState != 2) begin
        mGapOk = (mState == 1) && (mGap >= MGAP);
        mHigh = (mFilt == 3);
        mState = 2;
      end else begin
        if (mFilt == 3 && mGapOk && mWidth == BLOW - 1) eBlow = 1;
        if (mFilt == 3) mHigh = 1;
      end
      mGap   = (mFilt == 1) ? ((mGap < CMAX) ? mGap + 1 : mGap) : 0;
      mWidth = (mFilt >= 2) ? ((mWidth < CMAX) ? mWidth + 1 : mWidth) : 0;
      if (supLvl == mLast) mRun = (mRun < FILT) ? mRun + 1 : mRun;
      else mRun = 1;
      mLast = supLvl;
      if (mRun == FILT) mFilt = supLvl;
    end
  end

  task automatic check(string tag, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!done) begin
      check("R3 midDone vs model", midDone, eMid);
      check("R4 keyDone vs model", keyDone, eKey);
      check("R5 blowStart vs model", blowStart, eBlow);
      check("R6 pulseErr vs model", pulseErr, eErr);
      check("R8 pwrLoss vs model", pwrLoss, ePwr);
      check("R9 one event per cycle",
            int'(midDone) + keyDone + blowStart + pulseErr + pwrLoss <= 1, 1);
      if (rstN) begin
        cMid += midDone; cKey += keyDone; cBlow += blowStart;
        cErr += pulseErr; cPwr += pwrLoss;
      end
    end
  end

  task automatic hold(int lvl, int n);
    supLvl = 2'(lvl);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectCounts(string tag, int m, int k, int b, int e, int p);
    check({tag, " mid count"}, cMid, m);
    check({tag, " key count"}, cKey, k);
    check({tag, " blow count"}, cBlow, b);
    check({tag, " err count"}, cErr, e);
    check({tag, " loss count"}, cPwr, p);
    {cMid, cKey, cBlow, cErr, cPwr} = '0;
  endtask

  initial begin
    {cMid, cKey, cBlow, cErr, cPwr} = '0;
    repeat (3) @(negedge clk);
    check("R1 outputs in reset", {midDone, keyDone, blowStart, pulseErr, pwrLoss}, 0);
    rstN = 1'b1;
    hold(0, 5);
    check("R1 outputs after reset", {midDone, keyDone, blowStart, pulseErr, pwrLoss}, 0);
    hold(1, 40);
    expectCounts("R1 power-up", 0, 0, 0, 0, 0);
    hold(2, 30); hold(1, 40);
    expectCounts("R3 mid pulse", 1, 0, 0, 0, 0);
    hold(3, 30); hold(1, 40);
    expectCounts("R4 key pulse", 0, 1, 0, 0, 0);
    hold(2, 2); hold(3, 30); hold(2, 2); hold(1, 40);
    expectCounts("R7 high via mid", 0, 1, 0, 0, 0);
    hold(2, 10); hold(1, 40);
    expectCounts("R6 short pulse", 0, 0, 0, 1, 0);
    hold(3, 30); hold(1, 10); hold(2, 30); hold(1, 40);
    expectCounts("R6 short gap", 0, 1, 0, 1, 0);
    hold(3, 120); hold(1, 40);
    expectCounts("R5 blow pulse", 0, 0, 1, 0, 0);
    for (int i = 0; i < 5; i++) begin hold(2, 2); hold(1, 6); hold(3, 3); hold(1, 6); end
    expectCounts("R2 glitches ignored", 0, 0, 0, 0, 0);
    hold(3, 30); hold(0, 10);
    expectCounts("R8 cut pulse", 0, 0, 0, 0, 1);
    hold(1, 40); hold(2, 30); hold(1, 40);
    expectCounts("R8 recovery", 1, 0, 0, 0, 0);
    hold(0, 10); hold(2, 30); hold(1, 40);
    expectCounts("R8 pulse from ground", 0, 0, 0, 1, 1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nTests++; nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule